// File: doc/BRIEF.md
# Hysteretic Frequency Lock Detector

This block decides whether a divided-down recovered clock runs at the same frequency as a reference clock. The recovered clock drives a free-running edge counter. Its value crosses into the reference domain as a Gray code. Over a window of 2^WIN_LOG2 reference cycles, the block measures how many recovered edges arrived and takes the absolute difference from the nominal count. It then compares that difference with two thresholds. The enter-lock threshold is the tighter one, and the exit-lock threshold is the looser one.

The loss-of-lock alarm is active high. It is set at reset and after a calibration or powerdown mask is released. It clears only after one complete measured window falls inside the enter-lock threshold. While the loop is unlocked, the block sends a one-cycle reacquire request to the loop after every fixed number of windows. A reference-activity flag from outside forces the alarm on when the reference is dead. The mask from the powerdown sequencer silences the alarm and restarts the measurement.

With the defaults (2^16-cycle window, 39 and 20 counts), the thresholds correspond to roughly 600 ppm to drop lock and 300 ppm to regain it.

Top module: `fld_lock_detect`

## Requirements
- R1: While rst_ni is low, and directly after it is released, lol_o is 1 and reacq_o is 0.
- R2: The recovered-clock edge count is carried into the reference domain as a Gray code that changes by at most one bit per recovered edge. The measured difference for a window is |recovered edges - 2^WIN_LOG2|, and a window is 2^WIN_LOG2 reference cycles.
- R3: While unlocked, a window whose difference is <= ENTER_THR makes lol_o go to 0. The first window after reset or after mask release only primes the measurement and can never clear the alarm.
- R4: While locked, a window whose difference is > EXIT_THR makes lol_o go to 1.
- R5: A difference above ENTER_THR and at most EXIT_THR leaves the current state unchanged, whether that state is locked or unlocked.
- R6: While unlocked, reacq_o is a single-cycle pulse. It repeats every REACQ_WIN windows, which is exactly REACQ_WIN * 2^WIN_LOG2 reference cycles.
- R7: reacq_o stays 0 while locked.
- R8: When ref_active_i is 0 and cal_mask_i is 0, lol_o is 1 in every state, without waiting for a reference edge.
- R9: While cal_mask_i is 1, lol_o and reacq_o are 0. On release the state is unlocked (lol_o = 1), and lock again needs the prime window followed by one in-range window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Reference clock; all decision logic runs on it |
| rec_clk_i | input | 1 | Divided-down recovered clock |
| rst_ni | input | 1 | Active-low asynchronous reset, both domains |
| ref_active_i | input | 1 | 1 when the reference clock is seen toggling |
| cal_mask_i | input | 1 | Powerdown/calibration mask from the sequencer |
| lol_o | output | 1 | Loss-of-lock alarm, active high |
| reacq_o | output | 1 | One-cycle request to retry acquisition |

## Verification
Several properties are checked by assertions on every cycle:
- the Gray count moves by at most one bit per recovered edge;
- each measurement and each reacquire request lasts exactly one cycle;
- no request is raised while locked;
- every change of lock state has a qualifying measurement (or the mask) one cycle earlier.

Other behaviours need the bench's scenarios with real frequency offsets: the hysteresis band, where a mid-range offset holds whichever state came before, the exact spacing between requests, the immediate effect of a dead reference, and the re-priming that follows mask release.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  typedef enum logic {
    LK_UNLOCKED = 1'b0,
    LK_LOCKED   = 1'b1
  } lock_state_e;
endpackage

// File: rtl/fld_rec_counter.sv
`timescale 1ns/1ps
module fld_rec_counter #(
  parameter int CNT_W = 18
) (
  input  logic             rec_clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q;
  logic [CNT_W-1:0] bin_nx;

  assign bin_nx = bin_q + 1'b1;

  always_ff @(posedge rec_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bin_q  <= '0;
      gray_o <= '0;
    end else begin
      bin_q  <= bin_nx;
      gray_o <= bin_nx ^ (bin_nx >> 1);
    end
  end

  p_gray_step_r2: assert property (@(posedge rec_clk_i) disable iff (!rst_ni)
    $countones(gray_o ^ $past(gray_o)) <= 1);
endmodule

// File: rtl/fld_gray_sync.sv
`timescale 1ns/1ps
module fld_gray_sync #(
  parameter int CNT_W = 18
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  logic [CNT_W-1:0] meta_q, sync_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_i;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    bin_o[CNT_W-1] = sync_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) bin_o[i] = bin_o[i+1] ^ sync_q[i];
  end
endmodule

// File: rtl/fld_window.sv
`timescale 1ns/1ps
module fld_window #(
  parameter int WIN_LOG2 = 16,
  parameter int CNT_W    = WIN_LOG2 + 2
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] rec_cnt_i,
  output logic             tick_o,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] diff_o
);
  localparam logic [CNT_W-1:0] NOM = CNT_W'(1) << WIN_LOG2;

  logic [WIN_LOG2-1:0] win_q;
  logic [CNT_W-1:0]    prev_q;
  logic                primed_q;
  logic                win_end;
  logic [CNT_W-1:0]    delta;

  assign win_end = (win_q == '1);
  assign delta   = rec_cnt_i - prev_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q        <= '0;
      prev_q       <= '0;
      primed_q     <= 1'b0;
      tick_o       <= 1'b0;
      meas_valid_o <= 1'b0;
      diff_o       <= '0;
    end else if (restart_i) begin
      win_q        <= '0;
      primed_q     <= 1'b0;
      tick_o       <= 1'b0;
      meas_valid_o <= 1'b0;
    end else begin
      win_q        <= win_q + 1'b1;
      tick_o       <= win_end;
      meas_valid_o <= win_end && primed_q;
      if (win_end) begin
        prev_q   <= rec_cnt_i;
        primed_q <= 1'b1;
        diff_o   <= (delta >= NOM) ? (delta - NOM) : (NOM - delta);
      end
    end
  end

  p_meas_single_r2: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    meas_valid_o |=> !meas_valid_o);
  p_meas_on_tick_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    meas_valid_o |-> tick_o);
endmodule

// File: rtl/fld_lock_fsm.sv
`timescale 1ns/1ps
module fld_lock_fsm
  import fld_pkg::*;
#(
  parameter int CNT_W     = 18,
  parameter int ENTER_THR = 20,
  parameter int EXIT_THR  = 39,
  parameter int REACQ_WIN = 16
) (
  input  logic             ref_clk_i,
  input  logic             rst_ni,
  input  logic             mask_i,
  input  logic             tick_i,
  input  logic             meas_valid_i,
  input  logic [CNT_W-1:0] diff_i,
  output lock_state_e      state_o,
  output logic             reacq_o
);
  localparam int RW = (REACQ_WIN > 1) ? $clog2(REACQ_WIN) : 1;
  localparam logic [RW-1:0] RLAST = RW'(REACQ_WIN - 1);

  logic [RW-1:0] rcnt_q;
  logic          enter_ok, exit_bad;

  assign enter_ok = meas_valid_i && (diff_i <= CNT_W'(ENTER_THR));
  assign exit_bad = meas_valid_i && (diff_i >  CNT_W'(EXIT_THR));

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o <= LK_UNLOCKED;
      rcnt_q  <= '0;
      reacq_o <= 1'b0;
    end else if (mask_i) begin
      state_o <= LK_UNLOCKED;
      rcnt_q  <= '0;
      reacq_o <= 1'b0;
    end else begin
      reacq_o <= 1'b0;
      if (state_o == LK_LOCKED) begin
        rcnt_q <= '0;
        if (exit_bad) state_o <= LK_UNLOCKED;
      end else if (enter_ok) begin
        state_o <= LK_LOCKED;
        rcnt_q  <= '0;
      end else if (tick_i) begin
        if (rcnt_q == RLAST) begin
          rcnt_q  <= '0;
          reacq_o <= 1'b1;
        end else begin
          rcnt_q <= rcnt_q + 1'b1;
        end
      end
    end
  end

  p_reacq_pulse_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    reacq_o |=> !reacq_o);
  p_no_reacq_locked_r7: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_o == LK_LOCKED) |-> !reacq_o);
  p_lock_cause_r3: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_o == LK_LOCKED) && ($past(state_o) == LK_UNLOCKED)
      |-> $past(meas_valid_i) && ($past(diff_i) <= CNT_W'(ENTER_THR)));
  p_unlock_cause_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    (state_o == LK_UNLOCKED) && ($past(state_o) == LK_LOCKED)
      |-> $past(mask_i) || ($past(meas_valid_i) && ($past(diff_i) > CNT_W'(EXIT_THR))));
  p_mask_clears_r9: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    mask_i |=> (state_o == LK_UNLOCKED) && !reacq_o);
endmodule

// File: rtl/fld_lock_detect.sv
`timescale 1ns/1ps
module fld_lock_detect
  import fld_pkg::*;
#(
  parameter int WIN_LOG2  = 16,
  parameter int ENTER_THR = 20,
  parameter int EXIT_THR  = 39,
  parameter int REACQ_WIN = 16
) (
  input  logic ref_clk_i,
  input  logic rec_clk_i,
  input  logic rst_ni,
  input  logic ref_active_i,
  input  logic cal_mask_i,
  output logic lol_o,
  output logic reacq_o
);
  localparam int CNT_W = WIN_LOG2 + 2;

  logic [CNT_W-1:0] rec_gray, rec_bin, diff;
  logic             tick, meas_valid, fsm_reacq;
  lock_state_e      state;

  fld_rec_counter #(.CNT_W(CNT_W)) u_rec_cnt (
    .rec_clk_i (rec_clk_i),
    .rst_ni    (rst_ni),
    .gray_o    (rec_gray)
  );

  fld_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .ref_clk_i (ref_clk_i),
    .rst_ni    (rst_ni),
    .gray_i    (rec_gray),
    .bin_o     (rec_bin)
  );

  fld_window #(.WIN_LOG2(WIN_LOG2), .CNT_W(CNT_W)) u_win (
    .ref_clk_i    (ref_clk_i),
    .rst_ni       (rst_ni),
    .restart_i    (cal_mask_i),
    .rec_cnt_i    (rec_bin),
    .tick_o       (tick),
    .meas_valid_o (meas_valid),
    .diff_o       (diff)
  );

  fld_lock_fsm #(
    .CNT_W(CNT_W), .ENTER_THR(ENTER_THR), .EXIT_THR(EXIT_THR), .REACQ_WIN(REACQ_WIN)
  ) u_fsm (
    .ref_clk_i    (ref_clk_i),
    .rst_ni       (rst_ni),
    .mask_i       (cal_mask_i),
    .tick_i       (tick),
    .meas_valid_i (meas_valid),
    .diff_i       (diff),
    .state_o      (state),
    .reacq_o      (fsm_reacq)
  );

  // dead reference cannot be seen by ref-domain flops, so the override is combinational
  assign lol_o   = !cal_mask_i && (!ref_active_i || (state == LK_UNLOCKED));
  assign reacq_o = fsm_reacq;

  p_reset_alarm_r1: assert property (@(posedge ref_clk_i)
    !rst_ni && !cal_mask_i |-> lol_o && !reacq_o);
endmodule

// File: tb/fld_lock_detect_bench.sv
`timescale 1ns/1ps
module fld_lock_detect_bench;
  localparam int WL   = 10;
  localparam int WIN  = 1 << WL;
  localparam int RQW  = 16;

  logic ref_clk = 1'b0, rec_clk = 1'b0, rst_n = 1'b0;
  logic ref_act = 1'b1, mask = 1'b0;
  logic lol, reacq;
  realtime rec_half = 10.2;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #10 ref_clk = ~ref_clk;
  always begin
    #(rec_half);
    rec_clk = ~rec_clk;
  end

  fld_lock_detect #(.WIN_LOG2(WL), .ENTER_THR(4), .EXIT_THR(8), .REACQ_WIN(RQW))
  u_fld_lock_detect (
    .ref_clk_i(ref_clk), .rec_clk_i(rec_clk), .rst_ni(rst_n),
    .ref_active_i(ref_act), .cal_mask_i(mask), .lol_o(lol), .reacq_o(reacq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_win(input int n);
    repeat (n * WIN) @(negedge ref_clk);
  endtask

  task automatic count_reacq(input int n_win, output int cnt);
    cnt = 0;
    for (int i = 0; i < n_win * WIN; i++) begin
      @(negedge ref_clk);
      if (reacq) cnt++;
    end
  endtask

  task automatic t_reset;
    repeat (5) @(negedge ref_clk);
    chk("R1 lol in reset", lol, 1);
    chk("R1 reacq in reset", reacq, 0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    chk("R1 lol after release", lol, 1);
    chk("R1 reacq after release", reacq, 0);
  endtask

  task automatic t_reacq_spacing;
    int t0, t1, w;
    wait_win(3);
    chk("R3 far offset stays unlocked", lol, 1);
    while (!reacq) @(negedge ref_clk);
    w = 0;
    while (reacq) begin w++; @(negedge ref_clk); end
    chk("R6 pulse width", w, 1);
    t0 = 1;
    while (!reacq) begin t0++; @(negedge ref_clk); end
    chk("R6 spacing", t0, RQW * WIN);
    t1 = 0;
    @(negedge ref_clk);
    chk("R6 second pulse width", reacq, 0);
  endtask

  task automatic t_lock;
    rec_half = 10.0;
    wait_win(3);
    chk("R3 nominal locks", lol, 0);
  endtask

  task automatic t_no_reacq_locked;
    int c;
    count_reacq(RQW + 2, c);
    chk("R7 no reacq while locked", c, 0);
  endtask

  task automatic t_hyst;
    rec_half = 10.06;
    wait_win(3);
    chk("R5 mid offset holds lock", lol, 0);
    rec_half = 10.2;
    wait_win(3);
    chk("R4 far offset drops lock", lol, 1);
    rec_half = 10.06;
    wait_win(3);
    chk("R5 mid offset holds unlock", lol, 1);
    rec_half = 10.0;
    wait_win(3);
    chk("R3 relock", lol, 0);
  endtask

  task automatic t_dead_ref;
    #3 ref_act = 1'b0;
    #1 chk("R8 dead ref forces alarm", lol, 1);
    @(negedge ref_clk);
    ref_act = 1'b1;
    @(negedge ref_clk);
    chk("R8 alarm clears with ref back", lol, 0);
  endtask

  task automatic t_mask;
    int c;
    mask = 1'b1;
    @(negedge ref_clk);
    chk("R9 mask silences alarm", lol, 0);
    ref_act = 1'b0;
    #1 chk("R9 mask beats dead ref", lol, 0);
    ref_act = 1'b1;
    count_reacq(2, c);
    chk("R9 no reacq under mask", c, 0);
    chk("R9 still silent", lol, 0);
    mask = 1'b0;
    @(negedge ref_clk);
    chk("R9 unlocked after release", lol, 1);
    repeat (WIN + WIN / 2) @(negedge ref_clk);
    chk("R3 prime window cannot lock", lol, 1);
    wait_win(2);
    chk("R9 relock after release", lol, 0);
  endtask

  initial begin
    t_reset();
    t_reacq_spacing();
    t_lock();
    t_no_reacq_locked();
    t_hyst();
    t_dead_ref();
    t_mask();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule